// File: doc/BRIEF.md
# Integer multiply/divide unit

This block performs the eight 32-bit integer multiply and divide operations for a processor datapath. A caller presents two operands and a 3-bit operation code together with a one-cycle start pulse. It then waits for a one-cycle done pulse, when the result is on the result port. The result stays there until the next accepted start.

All four multiply flavours are computed in a single cycle from one sign-extended double-width product. Division with a nonzero divisor runs a 32-step restoring shift-subtract loop on operand magnitudes, then corrects the signs. While that loop runs, the busy flag is high. Two cases bypass the loop and answer in one cycle: a zero divisor, and the signed quotient that cannot be represented. Both return fixed results.

Top module: `md_unit`

## Requirements
- R1: Operation code 0 returns the low 32 bits of the 64-bit product of the two operands.
- R2: Operation codes 1, 2 and 3 return the upper 32 bits of the product, with the operands taken as signed×signed (1), first signed × second unsigned (2), and unsigned×unsigned (3).
- R3: Operation code 4 returns the signed quotient rounded toward zero, and code 5 returns the unsigned quotient.
- R4: Operation code 6 returns the signed remainder, whose sign follows the dividend. Code 7 returns the unsigned remainder.
- R5: With a zero divisor, the quotient codes (4, 5) return all ones and the remainder codes (6, 7) return the dividend.
- R6: For code 4 or 6 with dividend 0x80000000 and divisor 0xFFFFFFFF, the quotient is 0x80000000 and the remainder is 0.
- R7: A multiply, a zero-divisor divide and the case in R6 raise done in the first cycle after the start edge, and busy stays low.
- R8: A divide with a nonzero divisor (other than the case in R6) raises busy from the cycle after the start edge until the result is ready. Done is raised within 40 cycles of the start edge, and busy is low whenever done is high.
- R9: A start pulse while busy is high is ignored. It does not change the running operation, its result or its timing.
- R10: Done is high for one cycle for each accepted operation. The result does not change except in the cycle in which done rises.
- R11: After reset, done and busy are low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when busy is low |
| op | input | 3 | Operation code 0..7 |
| opnd_a | input | 32 | First operand / dividend |
| opnd_b | input | 32 | Second operand / divisor |
| result | output | 32 | Result, held until the next accepted start |
| done | output | 1 | One-cycle pulse when result is ready |
| busy | output | 1 | High while a divide loop runs |

## Verification
Some properties are checked on every cycle by the assertions:
- done never occurs without a preceding accepted start or loop completion;
- the result never moves outside a done cycle;
- busy and done never overlap;
- a start during busy cannot end the loop early;
- the divider is never loaded with a zero divisor.

The numeric correctness of each operation code can only be shown by the bench's directed scenarios. This covers signedness mixes, rounding toward zero, the sign of the remainder and the two special divide results. The same holds for the exact latency of each path.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [2:0] {
    MD_MUL_LO  = 3'd0,
    MD_MUL_HSS = 3'd1,
    MD_MUL_HSU = 3'd2,
    MD_MUL_HUU = 3'd3,
    MD_DIV_S   = 3'd4,
    MD_DIV_U   = 3'd5,
    MD_REM_S   = 3'd6,
    MD_REM_U   = 3'd7
  } md_op_e;
endpackage

// File: rtl/md_mul_comb.sv
module md_mul_comb import md_pkg::*; #(
  parameter int W = 32
) (
  input  md_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);
  localparam int PW = 2 * W;

  // Sign-extend each operand to double width as the code asks, multiply,
  // keep the requested half.
  function automatic logic [W-1:0] pick_half(input md_op_e o, input logic [W-1:0] x,
                                             input logic [W-1:0] y);
    logic         xs, ys;
    logic [PW-1:0] ex, ey, full;
    xs   = (o == MD_MUL_HSS) || (o == MD_MUL_HSU);
    ys   = (o == MD_MUL_HSS);
    ex   = {{W{xs & x[W-1]}}, x};
    ey   = {{W{ys & y[W-1]}}, y};
    full = ex * ey;
    return (o == MD_MUL_LO) ? full[W-1:0] : full[PW-1:W];
  endfunction

  assign prod = pick_half(op, a, b);
endmodule

// File: rtl/md_div_iter.sv
module md_div_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;
  logic [W:0]    rem_sh, diff;
  logic          fits;

  // One restoring step: shift in the next dividend bit, subtract when it fits.
  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};
  assign fits   = ~diff[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0; rem_q <= '0; dvs_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; fin_q <= 1'b0;
    end else if (load) begin
      quo_q <= dvd_mag; rem_q <= '0; dvs_q <= dvs_mag;
      cnt_q <= STEPS; run_q <= 1'b1; fin_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= fits ? diff[W-1:0] : rem_sh[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      run_q <= (cnt_q != CW'(1));
      fin_q <= (cnt_q == CW'(1));
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;
  assign fin = fin_q;

  // R5
  nonzero_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (dvs_mag != '0));
  // R8
  fin_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !run_q);
  // R8
  run_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/md_unit.sv
module md_unit import md_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] x, input logic neg);
    return neg ? (~x + 1'b1) : x;
  endfunction

  md_op_e       op_e;
  logic         accept, is_div, div_sgn, want_rem, by_zero, ovf, special, div_load;
  logic [W-1:0] mul_res, special_res, dvd_mag, dvs_mag, core_quo, core_rem;
  logic         div_fin;
  logic [W-1:0] result_q;
  logic         done_q, busy_q, rem_sel_q, qneg_q, rneg_q;

  // Named events used by the control and the assertions.
  assign op_e     = md_op_e'(op);
  assign accept   = start && !busy_q;
  assign is_div   = op[2];
  assign div_sgn  = !op[0];
  assign want_rem = op[1];
  assign by_zero  = (opnd_b == '0);
  assign ovf      = div_sgn && (opnd_a == MIN_NEG) && (opnd_b == '1);
  assign special  = by_zero || ovf;
  assign div_load = accept && is_div && !special;

  assign special_res = by_zero ? (want_rem ? opnd_a : '1)
                               : (want_rem ? '0 : opnd_a);
  assign dvd_mag = magnitude(opnd_a, div_sgn);
  assign dvs_mag = magnitude(opnd_b, div_sgn);

  md_mul_comb #(.W(W)) u_mul (
    .op(op_e), .a(opnd_a), .b(opnd_b), .prod(mul_res)
  );

  md_div_iter #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .quo(core_quo), .rem(core_rem), .fin(div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0; done_q <= 1'b0; busy_q <= 1'b0;
      rem_sel_q <= 1'b0; qneg_q <= 1'b0; rneg_q <= 1'b0;
    end else if (accept) begin
      if (!is_div) begin
        result_q <= mul_res;
        done_q   <= 1'b1;
      end else if (special) begin
        result_q <= special_res;
        done_q   <= 1'b1;
      end else begin
        busy_q    <= 1'b1;
        done_q    <= 1'b0;
        rem_sel_q <= want_rem;
        qneg_q    <= div_sgn && (opnd_a[W-1] ^ opnd_b[W-1]);
        rneg_q    <= div_sgn && opnd_a[W-1];
      end
    end else if (div_fin) begin
      result_q <= rem_sel_q ? apply_sign(core_rem, rneg_q)
                            : apply_sign(core_quo, qneg_q);
      done_q   <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign result = result_q;
  assign done   = done_q;
  assign busy   = busy_q;

  // R10
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(accept) || $past(div_fin)));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !div_fin) |=> $stable(result_q));
  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);
  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !div_fin) |=> busy_q);
  // R7
  fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (!is_div || special)) |=> (done_q && !busy_q));
endmodule

// File: tb/tb_md_unit.sv
`timescale 1ns/1ps
module tb_md_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] result;
  logic        done, busy;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  md_unit #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .done(done), .busy(busy)
  );

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b);
    longint      sa, sb, ub, p;
    logic [63:0] up;
    int          q;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ub = longint'({32'b0, b});
    case (o)
      3'd0: begin p = sa * sb; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin up = {32'b0, a} * {32'b0, b}; return up[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a;
        q = $signed(a) / $signed(b); return q;
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 0;
        q = $signed(a) % $signed(b); return q;
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one op, wait for done, check value and latency.
  task automatic run_op(input string req, input logic [2:0] o,
                        input logic [31:0] a, input logic [31:0] b);
    int  lat;
    bit  slow;
    logic [31:0] exp;
    exp  = model(o, a, b);
    slow = o[2] && (b != 0) && !(!o[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (slow) check({req, " R8 busy after start"}, {31'b0, busy}, 32'd1);
    while (!done && lat < 60) begin
      @(negedge clk); lat++;
    end
    check(req, result, exp);
    if (slow) check({req, " R8 latency<=40"}, {31'b0, lat <= 40}, 32'd1);
    else      check({req, " R7 latency 1"}, lat, 32'd1);
    check({req, " R8 busy low at done"}, {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    check("R11 done", {31'b0, done}, 0);
    check("R11 busy", {31'b0, busy}, 0);
    check("R11 result", result, 0);
  endtask

  task automatic t_mul();
    run_op("R1 lo", 3'd0, 32'd12345, 32'd6789);
    run_op("R1 lo neg", 3'd0, 32'hFFFF_FFF9, 32'd13);
    run_op("R2 hss", 3'd1, 32'h8000_0000, 32'h8000_0000);
    run_op("R2 hss mix", 3'd1, 32'hFFFF_FFFE, 32'h7FFF_FFFF);
    run_op("R2 hsu", 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R2 hsu pos", 3'd2, 32'h1234_5678, 32'hF000_0000);
    run_op("R2 huu", 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_div();
    run_op("R3 divs", 3'd4, 32'hFFFF_FFF9, 32'd2);
    run_op("R3 divs negneg", 3'd4, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
    run_op("R3 divu", 3'd5, 32'hFFFF_FFF9, 32'd2);
    run_op("R3 divu big", 3'd5, 32'h8000_0000, 32'h8000_0001);
    run_op("R4 rems", 3'd6, 32'hFFFF_FFF9, 32'd2);
    run_op("R4 rems posneg", 3'd6, 32'd7, 32'hFFFF_FFFE);
    run_op("R4 remu", 3'd7, 32'hFFFF_FFF9, 32'd10);
  endtask

  task automatic t_special();
    run_op("R5 divs0", 3'd4, 32'hFFFF_FF00, 32'd0);
    run_op("R5 divu0", 3'd5, 32'd55, 32'd0);
    run_op("R5 rems0", 3'd6, 32'hFFFF_FF00, 32'd0);
    run_op("R5 remu0", 3'd7, 32'd55, 32'd0);
    run_op("R6 divs ovf", 3'd4, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R6 rems ovf", 3'd6, 32'h8000_0000, 32'hFFFF_FFFF);
    run_op("R3 divu notovf", 3'd5, 32'h8000_0000, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignore();
    int lat;
    int dones;
    logic [31:0] held;
    @(negedge clk);
    op = 3'd5; opnd_a = 32'd100; opnd_b = 32'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    op = 3'd0; opnd_a = 32'd3; opnd_b = 32'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 still busy", {31'b0, busy}, 1);
    check("R9 no early done", {31'b0, done}, 0);
    lat = 5;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    check("R9 result of first op", result, 32'd14);
    held = result;
    dones = 0;
    repeat (6) begin @(negedge clk); if (done) dones++; end
    check("R10 single done pulse", dones, 0);
    check("R10 result held", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mul();
    t_div();
    t_special();
    t_ignore();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule